// File: doc/BRIEF.md
# ADC Result Sequencer with Automatic Compare

This block decides where each result of an analog-to-digital conversion sequence is kept, and it can test results against stored limits on its own. A converter outside the block sends one `conv_done` pulse with `conv_data` for each finished conversion. Software or a controller starts a sequence with `seq_start` and stops it with `seq_abort`. `seq_last` gives the index of the last conversion in a sequence. In scan mode a sequence restarts by itself once its last conversion is done. A 4-bit conversion counter picks the result slot for every conversion. In normal mode the counter returns to zero at each sequence boundary. In FIFO mode it keeps running, so results from successive sequences fill the slots one after another.

Compare is enabled and given its sense per conversion number within the sequence, not per slot or channel. For an enabled conversion, software first writes the limit into the result slot that conversion will target. The arriving result is then tested against that limit and does not overwrite it. A successful test sets a sticky flag for that conversion number.

Top module: `adc_seq_cmp`

## Requirements
- R1: After reset, every result slot, the compare-enable, compare-sense and flag registers, and the counter read zero, and no sequence is running.
- R2: With FIFO mode off, `seq_start` sets the counter to 0 and marks a sequence as running. Conversion k of the sequence lands in slot k. After conversion `seq_last` the counter is 0 again.
- R3: With FIFO mode on, the counter is not reset at a sequence end. In scan mode it keeps counting across the automatic restarts. Without scan mode the sequence stops at the end and the counter holds its value.
- R4: The counter wraps from 15 to 0.
- R5: `seq_abort`, or any write to the compare-enable register (address 16), clears the counter and stops the sequence. While stopped, a `conv_done` pulse changes no slot, counter or flag.
- R6: `seq_start` clears the counter even in FIFO mode.
- R7: For a conversion whose compare is enabled, the result does not overwrite the target slot. With compare disabled, the result is written into the slot.
- R8: Compare-sense bit = 1 means the test succeeds when result > stored value. Sense bit = 0 means it succeeds when result <= stored value. A successful test sets flag bit n, where n is the conversion number.
- R9: Enable bit n and sense bit n belong to conversion number n within the sequence (0 to 7). The limit is taken from the slot the counter points to. Conversions numbered 8 and above are never compared.
- R10: Writing 1 to a flag bit (address 18) clears it, and writing 0 leaves it unchanged. A flag being set in the same cycle as a clear of that bit stays set.
- R11: A `conv_done` pulse while no sequence is running has no effect.
- R12: Register map: slots at addresses 0 to 15 (result in bits 11:0), compare-enable at 16, compare-sense at 17, flags at 18, and status at 19 with bit 4 = running and bits 3:0 = counter. The status register is read only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | Keep the counter across sequence ends |
| scan_mode | input | 1 | Restart the sequence automatically after its last conversion |
| seq_last | input | 4 | Index of the last conversion in a sequence |
| seq_start | input | 1 | Start a new sequence (pulse) |
| seq_abort | input | 1 | Abort the running sequence (pulse) |
| conv_done | input | 1 | Conversion finished (pulse) |
| conv_data | input | 12 | Result of the finished conversion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| conv_cnt | output | 4 | Current conversion counter |
| seq_busy | output | 1 | A sequence is running |
| cmp_flags | output | 8 | Compare flags, one per conversion number |

## Verification
The hardest case to reach is a conversion number that differs from the counter value. This only happens in FIFO scan mode, once a restarted sequence begins again at conversion 0 while the counter is already partway through the slots. The stimulus sets a two-conversion sequence with FIFO and scan on, and preloads a limit into slot 2. It then runs four conversions, so the third one uses enable bit 0 while it reads and guards slot 2. A second hard case is a flag clear that arrives in the same cycle as a successful compare. The bench drives the clear write and the `conv_done` pulse on the same edge.

// File: rtl/adc_seq_cmp.sv
module adc_seq_cmp #(
  parameter int DW   = 12,
  parameter int CW   = 4,
  parameter int NCMP = 8,
  parameter int RW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              scan_mode,
  input  logic [CW-1:0]     seq_last,
  input  logic              seq_start,
  input  logic              seq_abort,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_data,
  input  logic              reg_wr,
  input  logic [CW:0]       reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic [CW-1:0]     conv_cnt,
  output logic              seq_busy,
  output logic [NCMP-1:0]   cmp_flags
);
  localparam int NSLOT = 1 << CW;
  localparam int AW    = CW + 1;
  localparam logic [AW-1:0] A_EN    = AW'(NSLOT);
  localparam logic [AW-1:0] A_SENSE = AW'(NSLOT + 1);
  localparam logic [AW-1:0] A_FLAG  = AW'(NSLOT + 2);
  localparam logic [AW-1:0] A_STAT  = AW'(NSLOT + 3);
  localparam logic [CW:0]   NCMP_W  = (CW+1)'(NCMP);

  logic [DW-1:0]   slot_q [NSLOT];
  logic [NCMP-1:0] en_q, sense_q, flag_q;
  logic [CW-1:0]   cnt_q, idx_q;
  logic            busy_q;

  wire kill = seq_abort | (reg_wr && reg_addr == A_EN);
  wire take = conv_done & busy_q & ~kill & ~seq_start;
  wire last = (idx_q == seq_last);

  wire [NCMP-1:0] idx_hot = ({1'b0, idx_q} < NCMP_W) ? (NCMP'(1) << idx_q) : '0;
  wire            cmp_sel = |(idx_hot & en_q);
  wire            cmp_gt  = |(idx_hot & sense_q);
  wire [DW-1:0]   ref_val = slot_q[cnt_q];
  wire            hit     = cmp_gt ? (conv_data > ref_val) : (conv_data <= ref_val);
  wire [NCMP-1:0] f_set   = (take && hit) ? (idx_hot & en_q) : '0;
  wire [NCMP-1:0] f_clr   = (reg_wr && reg_addr == A_FLAG) ? reg_wdata[NCMP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (kill) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (seq_start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (take) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      cnt_q <= (last && !fifo_mode) ? '0 : cnt_q + 1'b1;
      if (last && !scan_mode) busy_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (take && cnt_q == CW'(i) && !cmp_sel)
        slot_q[i] <= conv_data;
      else if (reg_wr && reg_addr == AW'(i))
        slot_q[i] <= reg_wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      sense_q <= '0;
      flag_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_EN)    en_q    <= reg_wdata[NCMP-1:0];
      if (reg_wr && reg_addr == A_SENSE) sense_q <= reg_wdata[NCMP-1:0];
      flag_q <= (flag_q & ~f_clr) | f_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < AW'(NSLOT))
      reg_rdata = RW'(slot_q[reg_addr[CW-1:0]]);
    else
      case (reg_addr)
        A_EN:    reg_rdata = RW'(en_q);
        A_SENSE: reg_rdata = RW'(sense_q);
        A_FLAG:  reg_rdata = RW'(flag_q);
        A_STAT:  reg_rdata = RW'({busy_q, cnt_q});
        default: reg_rdata = '0;
      endcase
  end

  assign conv_cnt  = cnt_q;
  assign seq_busy  = busy_q;
  assign cmp_flags = flag_q;
endmodule

module adc_seq_cmp_chk #(
  parameter int CW   = 4,
  parameter int NCMP = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fifo_mode,
  input logic            seq_start,
  input logic            seq_abort,
  input logic            conv_done,
  input logic            reg_wr,
  input logic [CW:0]     reg_addr,
  input logic [CW-1:0]   conv_cnt,
  input logic            seq_busy,
  input logic [NCMP-1:0] cmp_flags
);
  localparam logic [CW:0] A_EN = (CW+1)'(1 << CW);
  wire en_wr = reg_wr && reg_addr == A_EN;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (conv_cnt == '0 && !seq_busy && cmp_flags == '0));

  a_r5_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_abort || en_wr) |=> (conv_cnt == '0 && !seq_busy));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !seq_abort && !en_wr) |=> (conv_cnt == '0 && seq_busy));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !seq_start && !seq_abort && !en_wr) |=> $stable(conv_cnt) && !seq_busy);

  a_r4_fifo_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && seq_busy && conv_done && !seq_start && !seq_abort && !en_wr)
      |=> conv_cnt == CW'($past(conv_cnt) + 1'b1));

  a_r8_flag_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> ((cmp_flags & ~$past(cmp_flags)) == '0));
endmodule

bind adc_seq_cmp adc_seq_cmp_chk #(.CW(CW), .NCMP(NCMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .seq_start(seq_start),
  .seq_abort(seq_abort), .conv_done(conv_done), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .conv_cnt(conv_cnt), .seq_busy(seq_busy),
  .cmp_flags(cmp_flags)
);

// File: tb/test_adc_seq_cmp.sv
module test_adc_seq_cmp;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_EN = 5'd16, A_SENSE = 5'd17, A_FLAG = 5'd18, A_STAT = 5'd19;

  logic clk = 0, rst_n = 0;
  logic fifo_mode = 0, scan_mode = 0, seq_start = 0, seq_abort = 0, conv_done = 0, reg_wr = 0;
  logic [3:0] seq_last = 0;
  logic [11:0] conv_data = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [3:0] conv_cnt;
  logic seq_busy;
  logic [7:0] cmp_flags;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_cmp i_adc_seq_cmp (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .scan_mode(scan_mode),
    .seq_last(seq_last), .seq_start(seq_start), .seq_abort(seq_abort),
    .conv_done(conv_done), .conv_data(conv_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_cnt(conv_cnt), .seq_busy(seq_busy), .cmp_flags(cmp_flags)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(string tag, logic [4:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic start();
    @(negedge clk); seq_start = 1; @(negedge clk); seq_start = 0;
  endtask

  task automatic abort();
    @(negedge clk); seq_abort = 1; @(negedge clk); seq_abort = 0;
  endtask

  task automatic conv(logic [11:0] d);
    @(negedge clk); conv_done = 1; conv_data = d; @(negedge clk); conv_done = 0;
  endtask

  task automatic t_reset();
    check("R1 cnt", 16'(conv_cnt), 0);
    check("R1 busy", 16'(seq_busy), 0);
    check("R1 flags", 16'(cmp_flags), 0);
    chk_reg("R1 slot5", 5'd5, 0);
    chk_reg("R1 enable", A_EN, 0);
    chk_reg("R1 sense", A_SENSE, 0);
  endtask

  task automatic t_normal();
    fifo_mode = 0; scan_mode = 0; seq_last = 3;
    start();
    check("R2 start cnt", 16'(conv_cnt), 0);
    check("R2 start busy", 16'(seq_busy), 1);
    for (int i = 0; i < 4; i++) begin
      conv(12'h100 + 12'(i));
      if (i < 3) check("R2 cnt step", 16'(conv_cnt), 16'(i + 1));
    end
    check("R2 end cnt", 16'(conv_cnt), 0);
    check("R2 end busy", 16'(seq_busy), 0);
    for (int i = 0; i < 4; i++) chk_reg("R2 slot", 5'(i), 16'h100 + 16'(i));
    chk_reg("R12 status", A_STAT, 0);
  endtask

  task automatic t_idle();
    conv(12'hABC);
    chk_reg("R11 slot0", 5'd0, 16'h100);
    check("R11 cnt", 16'(conv_cnt), 0);
    check("R11 busy", 16'(seq_busy), 0);
  endtask

  task automatic t_fifo();
    fifo_mode = 1; scan_mode = 0; seq_last = 2;
    start();
    repeat (3) conv(12'h055);
    check("R3 fifo end cnt", 16'(conv_cnt), 3);
    check("R3 fifo end busy", 16'(seq_busy), 0);
    start();
    check("R6 start cnt in fifo", 16'(conv_cnt), 0);
    chk_reg("R12 status busy", A_STAT, 16'h10);
    abort();
    scan_mode = 1; seq_last = 3;
    start();
    for (int k = 0; k < 20; k++) begin
      conv(12'h400 + 12'(k));
      if (k == 15) check("R4 wrap", 16'(conv_cnt), 0);
    end
    check("R3 scan cnt", 16'(conv_cnt), 4);
    check("R3 scan busy", 16'(seq_busy), 1);
    chk_reg("R3 slot3", 5'd3, 16'h413);
    chk_reg("R3 slot4", 5'd4, 16'h404);
    abort();
    check("R5 abort cnt", 16'(conv_cnt), 0);
    check("R5 abort busy", 16'(seq_busy), 0);
    conv(12'hEEE);
    chk_reg("R5 slot0 kept", 5'd0, 16'h410);
    fifo_mode = 0; seq_last = 1;
    start();
    conv(12'h001);
    check("R2 scan cnt1", 16'(conv_cnt), 1);
    conv(12'h002);
    check("R2 scan end cnt", 16'(conv_cnt), 0);
    check("R2 scan busy", 16'(seq_busy), 1);
    abort();
    scan_mode = 0;
  endtask

  task automatic t_en_kill();
    fifo_mode = 0; seq_last = 3;
    start();
    conv(12'h010);
    check("R5 pre cnt", 16'(conv_cnt), 1);
    wr(A_EN, 0);
    check("R5 en write cnt", 16'(conv_cnt), 0);
    check("R5 en write busy", 16'(seq_busy), 0);
  endtask

  task automatic t_compare();
    fifo_mode = 0; scan_mode = 0; seq_last = 3;
    for (int i = 0; i < 3; i++) wr(5'(i), 16'h200);
    wr(A_SENSE, 16'h05);
    wr(A_EN, 16'h07);
    wr(A_FLAG, 16'hFF);
    start();
    conv(12'h300); conv(12'h300); conv(12'h100); conv(12'h155);
    check("R8 flags gt/le", 16'(cmp_flags), 16'h01);
    for (int i = 0; i < 3; i++) chk_reg("R7 slot kept", 5'(i), 16'h200);
    chk_reg("R7 slot3 written", 5'd3, 16'h155);
    start();
    conv(12'h200);
    check("R8 equal not gt", 16'(cmp_flags), 16'h01);
    conv(12'h200);
    check("R8 equal le", 16'(cmp_flags), 16'h03);
    conv(12'h201);
    check("R8 gt by one", 16'(cmp_flags), 16'h07);
    conv(12'h000);
    wr(A_FLAG, 16'h02);
    check("R10 w1c", 16'(cmp_flags), 16'h05);
    chk_reg("R12 flag read", A_FLAG, 16'h05);
    start();
    @(negedge clk);
    conv_done = 1; conv_data = 12'h300;
    reg_wr = 1; reg_addr = A_FLAG; reg_wdata = 16'h01;
    @(negedge clk);
    conv_done = 0; reg_wr = 0;
    check("R10 set beats clear", 16'(cmp_flags), 16'h05);
    abort();
  endtask

  task automatic t_fifo_index();
    wr(A_FLAG, 16'hFF);
    wr(A_EN, 16'h01);
    wr(A_SENSE, 16'h01);
    wr(5'd0, 16'hFFF);
    wr(5'd2, 16'h080);
    fifo_mode = 1; scan_mode = 1; seq_last = 1;
    start();
    conv(12'h000);
    check("R9 conv0 no hit", 16'(cmp_flags), 0);
    conv(12'h111);
    conv(12'h090);
    check("R9 flag by conv number", 16'(cmp_flags), 16'h01);
    conv(12'h333);
    abort();
    chk_reg("R9 slot0 kept", 5'd0, 16'hFFF);
    chk_reg("R9 slot1", 5'd1, 16'h111);
    chk_reg("R9 slot2 limit kept", 5'd2, 16'h080);
    chk_reg("R9 slot3", 5'd3, 16'h333);
    scan_mode = 0; fifo_mode = 0;
  endtask

  task automatic t_high_index();
    wr(A_SENSE, 0);
    wr(A_EN, 16'hFF);
    seq_last = 9;
    start();
    for (int i = 0; i < 8; i++) conv(12'h7FF);
    conv(12'h011);
    conv(12'h022);
    chk_reg("R9 slot8 written", 5'd8, 16'h011);
    chk_reg("R9 slot9 written", 5'd9, 16'h022);
    chk_reg("R7 slot0 kept", 5'd0, 16'hFFF);
    check("R9 end busy", 16'(seq_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_idle();
    t_fifo();
    t_en_kill();
    t_compare();
    t_fifo_index();
    t_high_index();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule